// File: doc/BRIEF.md
# Up-Counting Overflow Timer

This block is a general-purpose event timer. A counter climbs by one on every clock while running and produces an overflow event when it steps past all-ones. Software gets an event N+1 clocks after start by writing the counter with all-ones minus N and then setting the run bit. Deltas smaller than a floor of three are raised to that floor by the hardware.

The timer works in two modes. In one-shot mode the run bit drops when the counter wraps and the counter then sits at zero. In periodic mode the counter takes the reload value on every wrap and keeps counting. A sticky overflow flag, cleared by writing one to it, combines with an enable bit to drive a level interrupt. Software reaches everything through a small synchronous register port. A write takes effect at the clock edge on which the write strobe is high. Reads are combinational and have no side effects.

Top module: `wrap_timer`

## Requirements
- R1: After reset all four registers read zero and `irq` is low.
- R2: While the run bit (address 0, bit 0) is set, the counter (address 2) increases by one at every clock edge on which no register write occurs.
- R3: With the run bit clear, the counter holds its value. Writing address 0 with bit 0 clear stops a running counter after the edge of that write.
- R4: In one-shot mode (address 0, bit 1 clear), a running counter at all-ones becomes zero at the next edge. At that edge the run bit clears and the overflow flag sets. A start value of all-ones minus N therefore wraps at the (N+1)-th edge after the run-bit write.
- R5: In periodic mode (address 0, bit 1 set), a running counter at all-ones takes the reload register value (address 1) at the next edge. The run bit stays set and the overflow flag sets.
- R6: Any value written to the counter or the reload register that is above all-ones minus 3 is stored as all-ones minus 3.
- R7: The overflow flag (address 3, bit 0) stays set until address 3 is written with bit 0 set. A wrap on the same edge as that clearing write leaves the flag set.
- R8: `irq` is high exactly when both the overflow flag and the interrupt enable (address 3, bit 1, written by every address-3 write) are set.
- R9: A counter write takes effect at its own edge and overrides both the increment and a wrap due on that edge.
- R10: Address 0 reads back run in bit 0 and periodic mode in bit 1. Address 3 reads back the flag in bit 0 and the enable in bit 1. All other bits of these two addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 reload, 2 counter, 3 status) |
| regWdata | input | CNT_W | Write data |
| regRdata | output | CNT_W | Combinational read data for `regAddr` |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches every cycle for the following: the single-step increment while running, the freeze while stopped, the two wrap outcomes with their flag setting, the clamp bound on stored values, the stickiness of the flag, and the gating of `irq`. Only the bench's scenarios can show the end-to-end event latency for a given delta. The same goes for the periodic interval repeating, the set-over-clear race on the exact wrap edge, and a counter write overriding a due wrap. All of these depend on a sequence of register writes landing on chosen edges.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RLD  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_STS  = 2'd3;

  typedef struct packed {
    logic cntWe;       // load counter from write data
    logic rldWe;       // load reload register from write data
    logic count;       // advance the counter this edge
    logic wrapReload;  // on wrap take reload value instead of zero
  } dpCtl_t;
endpackage

// File: rtl/timer_dp.sv
module timer_dp
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int MIN_DELTA = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] rldVal,
  output logic             wrapEvt
);
  localparam logic [CNT_W-1:0] ALL_ONES  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAX_START = ALL_ONES - CNT_W'(MIN_DELTA);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] clamped;
  logic             atTop;

  always_comb begin
    clamped = (wrData > MAX_START) ? MAX_START : wrData;
    atTop   = (cntVal == ALL_ONES);
    wrapEvt = dpCtl.count && atTop && !dpCtl.cntWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
      rldVal <= '0;
    end else begin
      if (dpCtl.rldWe) rldVal <= clamped;
      if (dpCtl.cntWe) begin
        cntVal <= clamped;
      end else if (dpCtl.count) begin
        if (atTop) cntVal <= dpCtl.wrapReload ? rldVal : '0;
        else       cntVal <= cntVal + ONE;
      end
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic             wrapEvt,
  output dpCtl_t           dpCtl,
  output logic             runBit,
  output logic             autoBit,
  output logic             ovfFlag,
  output logic             irqEnBit,
  output logic             irq
);
  logic ctrlWe, stsWe;

  always_comb begin
    ctrlWe           = regWe && (regAddr == ADDR_CTRL);
    stsWe            = regWe && (regAddr == ADDR_STS);
    dpCtl.cntWe      = regWe && (regAddr == ADDR_CNT);
    dpCtl.rldWe      = regWe && (regAddr == ADDR_RLD);
    dpCtl.count      = runBit;
    dpCtl.wrapReload = autoBit;
    irq              = ovfFlag && irqEnBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      autoBit  <= 1'b0;
      ovfFlag  <= 1'b0;
      irqEnBit <= 1'b0;
    end else begin
      if (ctrlWe) begin
        runBit  <= regWdata[0];
        autoBit <= regWdata[1];
      end else if (wrapEvt && !autoBit) begin
        runBit  <= 1'b0;
      end
      if (wrapEvt)                    ovfFlag <= 1'b1;
      else if (stsWe && regWdata[0])  ovfFlag <= 1'b0;
      if (stsWe) irqEnBit <= regWdata[1];
    end
  end
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int MIN_DELTA = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             irq
);
  dpCtl_t           dpCtl;
  logic [CNT_W-1:0] cntVal, rldVal;
  logic             wrapEvt, runBit, autoBit, ovfFlag, irqEnBit;

  timer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .wrapEvt(wrapEvt), .dpCtl(dpCtl),
    .runBit(runBit), .autoBit(autoBit), .ovfFlag(ovfFlag),
    .irqEnBit(irqEnBit), .irq(irq)
  );

  timer_dp #(.CNT_W(CNT_W), .MIN_DELTA(MIN_DELTA)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wrData(regWdata),
    .cntVal(cntVal), .rldVal(rldVal), .wrapEvt(wrapEvt)
  );

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: regRdata[1:0] = {autoBit, runBit};
      ADDR_RLD:  regRdata      = rldVal;
      ADDR_CNT:  regRdata      = cntVal;
      ADDR_STS:  regRdata[1:0] = {irqEnBit, ovfFlag};
      default:   regRdata      = '0;
    endcase
  end
endmodule

// File: rtl/wrap_timer_chk.sv
module wrap_timer_chk #(
  parameter int CNT_W     = 32,
  parameter int MIN_DELTA = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [1:0]       regAddr,
  input logic [CNT_W-1:0] regWdata,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] rldVal,
  input logic             runBit,
  input logic             autoBit,
  input logic             ovfFlag,
  input logic             irqEnBit,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ALL_ONES  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAX_START = ALL_ONES - CNT_W'(MIN_DELTA);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
    runBit && !regWe && cntVal != ALL_ONES |=> cntVal == $past(cntVal) + ONE); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runBit && !regWe |=> $stable(cntVal)); // R3
  AST_ONESHOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    runBit && !autoBit && cntVal == ALL_ONES && !regWe |=> cntVal == '0 && !runBit && ovfFlag); // R4
  AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    runBit && autoBit && cntVal == ALL_ONES && !regWe |=> cntVal == $past(rldVal) && runBit && ovfFlag); // R5
  AST_CNT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == 2'd2 |=> cntVal <= MAX_START); // R6
  AST_RLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rldVal <= MAX_START); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(regWe && regAddr == 2'd3 && regWdata[0]) |=> ovfFlag); // R7
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ovfFlag && irqEnBit); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && irqEnBit |-> irq); // R8
endmodule

bind wrap_timer wrap_timer_chk #(.CNT_W(CNT_W), .MIN_DELTA(MIN_DELTA)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .cntVal(cntVal), .rldVal(rldVal),
  .runBit(runBit), .autoBit(autoBit), .ovfFlag(ovfFlag),
  .irqEnBit(irqEnBit), .irq(irq)
);

// File: tb/tb_wrap_timer.sv
`timescale 1ns/1ps
module tb_wrap_timer;
  localparam logic [31:0] ALL  = 32'hFFFF_FFFF;
  localparam logic [31:0] MAXS = ALL - 32'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  wrap_timer dut (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
                  .regWdata(regWdata), .regRdata(regRdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] clampVal(input logic [31:0] v);
    return (v > MAXS) ? MAXS : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] d, v;
    int n, np;
    bit isAuto, en;
    void'($urandom(32'd1234));
    edges(3);
    rstN = 1'b1;
    edges(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reset reg", d, 32'd0);
    end
    chk("R1 irq reset", {31'd0, irq}, 32'd0);

    // R6 clamp of counter and reload writes
    wr(2'd2, ALL);         rd(2'd2, d); chk("R6 cnt all-ones", d, MAXS);
    wr(2'd2, ALL - 32'd2); rd(2'd2, d); chk("R6 cnt ones-2", d, MAXS);
    wr(2'd2, ALL - 32'd4); rd(2'd2, d); chk("R6 cnt ones-4", d, ALL - 32'd4);
    wr(2'd1, ALL - 32'd1); rd(2'd1, d); chk("R6 rld ones-1", d, MAXS);
    // R10 readback layout
    wr(2'd0, 32'h2); rd(2'd0, d); chk("R10 ctrl readback", d, 32'h2);
    wr(2'd0, 32'h0);

    // random one-shot and periodic runs
    for (int it = 0; it < 24; it++) begin
      n = int'($urandom_range(0, 30));
      isAuto = 1'($urandom_range(0, 1));
      en = 1'($urandom_range(0, 1));
      np = (n < 3) ? 3 : n;
      v = clampVal(ALL - 32'(n));
      wr(2'd2, ALL - 32'(n));
      wr(2'd1, ALL - 32'(n));
      wr(2'd3, {30'd0, en, 1'b1});
      wr(2'd0, {30'd0, isAuto, 1'b1});
      edges(np);
      rd(2'd2, d); chk("R2 count to top", d, ALL);
      rd(2'd3, d); chk("R4 flag before wrap", d & 32'h1, 32'h0);
      edges(1);
      rd(2'd3, d); chk("R4 flag at wrap", d & 32'h1, 32'h1);
      chk("R8 irq follows enable", {31'd0, irq}, {31'd0, en});
      rd(2'd0, d); chk("R4 run after wrap", d & 32'h1, {31'd0, isAuto});
      rd(2'd2, d); chk("R5 value after wrap", d, isAuto ? v : 32'd0);
      if (isAuto) begin
        edges(np + 1);
        rd(2'd2, d); chk("R5 period repeats", d, v);
        wr(2'd0, 32'h0);
        edges(3);
        rd(2'd2, d); chk("R3 hold after stop", d, v + 32'd1);
      end else begin
        edges(3);
        rd(2'd2, d); chk("R4 stays zero", d, 32'd0);
      end
    end

    // R7 set wins over clear on the wrap edge
    wr(2'd2, MAXS); wr(2'd0, 32'h1); edges(4);
    rd(2'd3, d); chk("R7 flag set first", d & 32'h1, 32'h1);
    wr(2'd2, MAXS); wr(2'd0, 32'h1); edges(3);
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R7 set wins", d & 32'h1, 32'h1);
    chk("R8 irq low when disabled", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h2);
    chk("R8 irq high when enabled", {31'd0, irq}, 32'd1);
    rd(2'd3, d); chk("R7 flag kept on bit0=0", d, 32'h3);
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk("R7 W1C clears", d, 32'h0);

    // R9 counter write while running
    wr(2'd2, 32'd100); wr(2'd0, 32'h1); edges(2);
    rd(2'd2, d); chk("R2 running count", d, 32'd102);
    wr(2'd2, 32'd500);
    rd(2'd2, d); chk("R9 write while running", d, 32'd500);
    edges(2);
    rd(2'd2, d); chk("R9 counts from written", d, 32'd502);
    wr(2'd0, 32'h0);
    wr(2'd2, MAXS); wr(2'd0, 32'h1); edges(3);
    wr(2'd2, 32'd7);
    rd(2'd2, d); chk("R9 overrides wrap", d, 32'd7);
    rd(2'd3, d); chk("R9 no flag", d & 32'h1, 32'h0);
    rd(2'd0, d); chk("R9 still running", d, 32'h1);
    wr(2'd0, 32'h0);
    finishRun();
  end
endmodule